// File: doc/BRIEF.md
# Serial-Drained Receive Bit FIFO

This block is a one-bit-wide store that sits behind a receiver's bit slicer. Each demodulated bit arrives with a single-cycle valid strobe and is queued in arrival order. A host empties the queue one bit at a time, in one of two ways. It can hold a select input low and pulse an external serial clock, so that the head bit appears on a serial data output. It can also issue a read command through the SPI command decoder, which returns the head bit on a separate output.

An interrupt flags that enough bits are waiting. The threshold is a programmable bit count. A mode bit changes the role of two shared pins. In raw mode, the first pin carries live receive data and the second pin carries the recovered data clock. In FIFO mode, the first pin becomes the select input and the second pin carries the interrupt.

The serial clock and the select input are sampled in the reference clock domain. The serial clock must run at one quarter of the reference rate or slower. Each phase of the serial clock must last at least two reference periods.

Top module: `rx_bit_fifo_top`

## Requirements
- R1: After the synchronous active-high `rst`, these all read 0: the stored-bit count, the overflow flag, the interrupt, `sdo` and `spi_bit`.
- R2: Each cycle with `wr_valid` high and room in the store appends `wr_bit` and raises the count by one. Bits leave in the order they were written.
- R3: A write while the count equals DEPTH, with no pop in the same cycle, is dropped. The count stays at DEPTH and the sticky overflow flag `stat_ovf` is set.
- R4: `stat_irq` is 1 exactly when the count is nonzero and at least `level`. With `level` = 1 it stays high while any bit remains.
- R5: In FIFO mode (`fifo_en` = 1) with `shr_a_in` low, `sdo` shows the head bit, or 0 when the store is empty. Each rising edge of `sck` removes one bit, and `sdo` settles within 8 reference cycles of that edge.
- R6: An `sck` rising edge has no effect on the count in two cases: when `shr_a_in` is high, or when `fifo_en` = 0.
- R7: A pop while the store is empty returns 0 and leaves the count at 0.
- R8: A one-cycle `spi_rd` pulse in FIFO mode removes the head bit. The following cycle presents that bit on `spi_bit`, which holds until the next such read.
- R9: With `fifo_en` = 0, `shr_a_out` = `raw_data_in`, `shr_a_oe` = 1 and `shr_b_out` = `raw_clk_in`. With `fifo_en` = 1, `shr_a_oe` = 0, `shr_a_out` = 0 and `shr_b_out` = `stat_irq`.
- R10: A cycle with `fifo_clr` high clears the count, the overflow flag and the interrupt.
- R11: A write and a pop in the same cycle leave the count unchanged. A write in that same cycle is accepted even when the store is full, and it does not set overflow. A write and a read in the same cycle on an empty store returns 0 and leaves one bit stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Synchronous store clear |
| fifo_en | input | 1 | Pin mode: 0 raw data/clock, 1 select/interrupt |
| level | input | CW | Interrupt threshold in bits |
| wr_valid | input | 1 | Single-cycle strobe for an incoming bit |
| wr_bit | input | 1 | Incoming demodulated bit |
| raw_data_in | input | 1 | Live receive data for raw mode |
| raw_clk_in | input | 1 | Recovered data clock for raw mode |
| sck | input | 1 | External serial clock, asynchronous |
| shr_a_in | input | 1 | Shared pin A input; select when `fifo_en` = 1, active low |
| spi_rd | input | 1 | One-cycle SPI read command strobe |
| shr_a_out | output | 1 | Shared pin A output value |
| shr_a_oe | output | 1 | Shared pin A output enable |
| shr_b_out | output | 1 | Shared pin B: raw clock or interrupt |
| sdo | output | 1 | Serial data output for the select-pin drain |
| spi_bit | output | 1 | Bit returned by the last SPI read |
| stat_count | output | CW | Number of stored bits |
| stat_ovf | output | 1 | Sticky overflow flag |
| stat_irq | output | 1 | Threshold interrupt status |

## Verification
A bit write and a pop can fall in the same reference cycle. So can a write and a clear. The case that matters most is a write and an SPI read on a full store, since a wrong priority there silently drops data or raises a false overflow. The bench drives `wr_valid` and `spi_rd` on the same edge in two cases: with the store full, and with it empty. It then judges the result in three ways. It checks the returned bit against the scoreboard head. It checks that the count is unchanged and that no overflow is flagged. It then drains the store and confirms that the simultaneously written bit came out last, in order.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  typedef enum logic {
    PINS_RAW  = 1'b0,
    PINS_FIFO = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/rbf_sync.sv
module rbf_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rbf_store.sv
module rbf_store #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          pop_req,
  output logic          head,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic          mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          is_empty, is_full, do_pop, do_wr, drop;

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CW'(DEPTH));
  assign do_pop   = pop_req && !is_empty;
  assign do_wr    = wr_en && (!is_full || do_pop);
  assign drop     = wr_en && is_full && !do_pop;

  // storage written without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (do_wr)
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_pop);
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign head  = is_empty ? 1'b0 : mem[rd_ptr];
  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/rbf_pinmux.sv
module rbf_pinmux
  import rbf_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      raw_data,
  input  logic      raw_clk,
  input  logic      irq,
  output logic      a_out,
  output logic      a_oe,
  output logic      b_out
);
  always_comb begin
    unique case (mode)
      PINS_RAW: begin
        a_out = raw_data;
        a_oe  = 1'b1;
        b_out = raw_clk;
      end
      default: begin
        a_out = 1'b0;
        a_oe  = 1'b0;
        b_out = irq;
      end
    endcase
  end
endmodule

// File: rtl/rx_bit_fifo_top.sv
module rx_bit_fifo_top
  import rbf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_clr,
  input  logic          fifo_en,
  input  logic [CW-1:0] level,
  input  logic          wr_valid,
  input  logic          wr_bit,
  input  logic          raw_data_in,
  input  logic          raw_clk_in,
  input  logic          sck,
  input  logic          shr_a_in,
  input  logic          spi_rd,
  output logic          shr_a_out,
  output logic          shr_a_oe,
  output logic          shr_b_out,
  output logic          sdo,
  output logic          spi_bit,
  output logic [CW-1:0] stat_count,
  output logic          stat_ovf,
  output logic          stat_irq
);
  logic [1:0]    sync_q;
  logic          sck_s, sel_n_s, sck_d;
  logic          sck_rise, sel_act, ser_pop, cmd_pop;
  logic          head;
  logic [CW-1:0] count;
  logic          ovf, irq;
  logic          sdo_q, spi_bit_q;

  rbf_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({shr_a_in, sck}),
    .q   (sync_q)
  );
  assign sck_s   = sync_q[0];
  assign sel_n_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign sck_rise = sck_s && !sck_d;
  assign sel_act  = fifo_en && !sel_n_s;
  assign ser_pop  = sel_act && sck_rise;
  assign cmd_pop  = fifo_en && spi_rd;

  rbf_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr     (fifo_clr),
    .wr_en   (wr_valid),
    .wr_bit  (wr_bit),
    .pop_req (ser_pop || cmd_pop),
    .head    (head),
    .count   (count),
    .ovf     (ovf)
  );

  assign irq = (count != '0) && (count >= level);

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q     <= 1'b0;
      spi_bit_q <= 1'b0;
    end else begin
      sdo_q <= sel_act ? head : 1'b0;
      if (cmd_pop) spi_bit_q <= head;
    end
  end

  rbf_pinmux u_pins (
    .mode     (pin_mode_e'(fifo_en)),
    .raw_data (raw_data_in),
    .raw_clk  (raw_clk_in),
    .irq      (irq),
    .a_out    (shr_a_out),
    .a_oe     (shr_a_oe),
    .b_out    (shr_b_out)
  );

  assign sdo        = sdo_q;
  assign spi_bit    = spi_bit_q;
  assign stat_count = count;
  assign stat_ovf   = ovf;
  assign stat_irq   = irq;
endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_clr,
  input logic          fifo_en,
  input logic          wr_valid,
  input logic [CW-1:0] stat_count,
  input logic          stat_ovf,
  input logic          stat_irq,
  input logic          shr_a_oe,
  input logic          shr_b_out
);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    stat_count <= CW'(DEPTH));

  p_ovf_from_full_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_ovf) |-> $past(stat_count) == CW'(DEPTH));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_ovf && !fifo_clr) |=> stat_ovf);

  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_clr) |-> (stat_count == $past(stat_count) ||
                          stat_count == $past(stat_count) + CW'(1) ||
                          stat_count + CW'(1) == $past(stat_count)));

  p_no_irq_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_count == '0) |-> !stat_irq);

  p_empty_stays_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_count == '0 && !wr_valid && !fifo_clr) |=> stat_count == '0);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (stat_count == '0 && !stat_ovf && !stat_irq));

  p_pin_role_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_en |-> (!shr_a_oe && shr_b_out == stat_irq));
endmodule

bind rx_bit_fifo_top rbf_checker #(.DEPTH(DEPTH)) u_rbf_checker (
  .clk        (clk),
  .rst        (rst),
  .fifo_clr   (fifo_clr),
  .fifo_en    (fifo_en),
  .wr_valid   (wr_valid),
  .stat_count (stat_count),
  .stat_ovf   (stat_ovf),
  .stat_irq   (stat_irq),
  .shr_a_oe   (shr_a_oe),
  .shr_b_out  (shr_b_out)
);

// File: tb/tb_rx_bit_fifo_top.sv
module tb_rx_bit_fifo_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst, fifo_clr, fifo_en, wr_valid, wr_bit;
  logic raw_data_in, raw_clk_in, sck, shr_a_in, spi_rd;
  logic [CW-1:0] level;
  logic shr_a_out, shr_a_oe, shr_b_out, sdo, spi_bit, stat_ovf, stat_irq;
  logic [CW-1:0] stat_count;

  rx_bit_fifo_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .fifo_en(fifo_en),
    .level(level), .wr_valid(wr_valid), .wr_bit(wr_bit),
    .raw_data_in(raw_data_in), .raw_clk_in(raw_clk_in), .sck(sck),
    .shr_a_in(shr_a_in), .spi_rd(spi_rd), .shr_a_out(shr_a_out),
    .shr_a_oe(shr_a_oe), .shr_b_out(shr_b_out), .sdo(sdo),
    .spi_bit(spi_bit), .stat_count(stat_count), .stat_ovf(stat_ovf),
    .stat_irq(stat_irq)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q[$];
  bit exp_ovf = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_irq();
    return (exp_q.size() != 0 && exp_q.size() >= int'(level)) ? 1 : 0;
  endfunction

  // driver: pushes a bit into the design and into the scoreboard
  task automatic push_bit(bit b);
    @(negedge clk);
    wr_bit = b; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    if (exp_q.size() < DEPTH) exp_q.push_back(b);
    else exp_ovf = 1'b1;
  endtask

  task automatic sck_pulse();
    @(negedge clk); sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor side: serial drain, compares against scoreboard head
  task automatic ser_read(string req);
    int e;
    e = (exp_q.size() != 0) ? int'(exp_q[0]) : 0;
    chk({req, " sdo head"}, int'(sdo), e);
    sck_pulse();
    if (exp_q.size() != 0) void'(exp_q.pop_front());
    chk({req, " count after sck"}, int'(stat_count), exp_q.size());
    chk("R4 irq vs count", int'(stat_irq), exp_irq());
  endtask

  task automatic spi_read(string req);
    int e;
    e = (exp_q.size() != 0) ? int'(exp_q.pop_front()) : 0;
    @(negedge clk); spi_rd = 1'b1;
    @(negedge clk); spi_rd = 1'b0;
    chk({req, " spi_bit"}, int'(spi_bit), e);
    chk({req, " count after read"}, int'(stat_count), exp_q.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; fifo_clr = 1'b0; fifo_en = 1'b0; wr_valid = 1'b0;
    wr_bit = 1'b0; raw_data_in = 1'b0; raw_clk_in = 1'b0; sck = 1'b0;
    shr_a_in = 1'b1; spi_rd = 1'b0; level = CW'(2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(stat_count), 0);
    chk("R1 ovf", int'(stat_ovf), 0);
    chk("R1 irq", int'(stat_irq), 0);
    chk("R1 sdo", int'(sdo), 0);
    chk("R1 spi_bit", int'(spi_bit), 0);

    // R9 raw mode pin roles
    raw_data_in = 1'b1; raw_clk_in = 1'b1; #1;
    chk("R9 raw a_out", int'(shr_a_out), 1);
    chk("R9 raw a_oe", int'(shr_a_oe), 1);
    chk("R9 raw b_out", int'(shr_b_out), 1);
    raw_data_in = 1'b0; raw_clk_in = 1'b0; #1;
    chk("R9 raw a_out low", int'(shr_a_out), 0);
    chk("R9 raw b_out low", int'(shr_b_out), 0);

    // R2 writes; R6 sck ignored in raw mode even with pin low
    push_bit(1'b1); push_bit(1'b0); push_bit(1'b1);
    chk("R2 count after writes", int'(stat_count), 3);
    shr_a_in = 1'b0;
    sck_pulse();
    chk("R6 raw mode sck ignored", int'(stat_count), 3);
    shr_a_in = 1'b1;

    // FIFO mode, R4 and R9
    @(negedge clk); fifo_en = 1'b1; #1;
    chk("R9 fifo a_oe", int'(shr_a_oe), 0);
    chk("R9 fifo a_out", int'(shr_a_out), 0);
    chk("R4 irq count3 level2", int'(stat_irq), 1);
    chk("R9 b_out is irq", int'(shr_b_out), 1);
    sck_pulse();
    chk("R6 select high sck ignored", int'(stat_count), 3);

    // R5 serial drain with select low, then R7 on empty
    shr_a_in = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 4; i++) ser_read("R5");
    chk("R7 serial empty count", int'(stat_count), 0);
    chk("R7 serial empty sdo", int'(sdo), 0);
    shr_a_in = 1'b1;
    repeat (4) @(negedge clk);

    // R4 polling with level 1
    level = CW'(1);
    push_bit(1'b0);
    chk("R4 level1 one bit irq", int'(stat_irq), 1);
    push_bit(1'b1);
    spi_read("R8");
    chk("R4 level1 irq still", int'(stat_irq), 1);
    spi_read("R8");
    chk("R4 level1 empty irq", int'(stat_irq), 0);
    spi_read("R7 spi empty");

    // R3 overflow then ordered readback
    for (int i = 0; i < DEPTH + 2; i++) push_bit(bit'((i * 5 + 1) % 3 == 0));
    chk("R3 count at full", int'(stat_count), DEPTH);
    chk("R3 ovf set", int'(stat_ovf), int'(exp_ovf));
    level = CW'(DEPTH);
    #1 chk("R4 full level16 irq", int'(stat_irq), 1);
    for (int i = 0; i < DEPTH; i++) spi_read("R2 order");
    chk("R3 ovf sticky", int'(stat_ovf), 1);

    // R10 clear
    push_bit(1'b1); push_bit(1'b1);
    level = CW'(1);
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
    exp_q.delete(); exp_ovf = 1'b0;
    chk("R10 count", int'(stat_count), 0);
    chk("R10 ovf", int'(stat_ovf), 0);
    chk("R10 irq", int'(stat_irq), 0);

    // R11 simultaneous write and read on a full store
    for (int i = 0; i < DEPTH; i++) push_bit(bit'(i[0]));
    @(negedge clk); wr_bit = 1'b1; wr_valid = 1'b1; spi_rd = 1'b1;
    @(negedge clk); wr_valid = 1'b0; spi_rd = 1'b0;
    chk("R11 full spi_bit", int'(spi_bit), int'(exp_q.pop_front()));
    exp_q.push_back(1'b1);
    chk("R11 full count unchanged", int'(stat_count), DEPTH);
    chk("R11 full no ovf", int'(stat_ovf), 0);
    for (int i = 0; i < DEPTH; i++) spi_read("R11 drain order");

    // R11 simultaneous on empty store
    @(negedge clk); wr_bit = 1'b1; wr_valid = 1'b1; spi_rd = 1'b1;
    @(negedge clk); wr_valid = 1'b0; spi_rd = 1'b0;
    exp_q.push_back(1'b1);
    chk("R11 empty spi_bit", int'(spi_bit), 0);
    chk("R11 empty count", int'(stat_count), 1);
    spi_read("R11 kept bit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule